// File: doc/BRIEF.md
# General-Purpose I/O Port with Modem-Line Reassignment

This block is an eight-pin general-purpose I/O port. A host reaches it through a small register bus with four registers. The direction register makes each pin an input or an output. The state register sets output levels on a write and returns pin levels on a read. The enable register arms a per-pin change interrupt. The control register selects the interrupt-clearing mode, selects pin usage and holds a self-clearing soft reset. Every pin input passes through a two-stage synchronizer before it is used. A pin can raise an interrupt only when it is an input and its enable bit is set. The interrupt output is the OR of all pending per-pin flags.

The clearing mode changes how a pending change is withdrawn. In transparent mode a flag follows the difference between the pin and its reference level. So a pin that returns to its old level withdraws its own interrupt. In latched mode the first differing level is captured and held in the state read-back, and the flag stays set until the host reads the state register. A read of the state register clears every flag and takes the current pin levels as the new reference.

A second control bit gives the top four pins to a serial port's modem lines. The pins, from the highest down, become ring indicator (RI), carrier detect (CD), data terminal ready (DTR) and data set ready (DSR). In that mode the three incoming lines appear on a status output with a one-cycle change pulse. The DTR pin is driven from an external control input. The port registers no longer affect those four pins.

Top module: `gpio_modem_port`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, and the direction, enable and control registers read 0.
- R2: The register at address 0 sets direction (bit = 1 makes the pin an output) and the one at address 2 holds the interrupt enables. Both read back what was written. A write to address 1 sets output levels. On a pin it does not own for modem use, `pin_oe` equals the direction bit and `pin_out` equals the written level.
- R3: A read of address 1 returns the written level for output pins. For input pins it returns the pin level after a two-cycle synchronizer, except as stated in R5.
- R4: Transparent mode (control bit 0 = 0). A level change on an eligible pin (input, enable set) raises `irq` on the third rising edge after the change. If the pin returns to its earlier level before the state register is read, `irq` drops again on the third edge after the return.
- R5: Latched mode (control bit 0 = 1). A change on an eligible pin raises `irq` and captures the new level. The flag stays set if the pin returns, and a read of address 1 returns the captured level for that pin until the read.
- R6: A read of address 1 clears every pending flag at that clock edge, so `irq` is 0 after it. Pin levels at that edge become the new reference.
- R7: Pins configured as outputs, or with their enable bit clear, never raise `irq`.
- R8: With control bit 1 set, pins 7, 6, 5 and 4 are RI, CD, DTR and DSR. The `pin_oe` bits are 0,0,1,0 for those pins and pin 5 drives `dtr_ctl`. The direction, state and enable bits 7..4 have no effect on those pins. Those pins raise no `irq`, and they read as 0 in the state register.
- R9: In modem mode `modem_lines` = {RI, CD, DSR}, taken from the synchronized pins. `modem_delta` is high for one cycle, the second edge after any of the three changes. With control bit 1 clear, both outputs are 0 and `dtr_ctl` has no effect on any pin.
- R10: In the control register, bit 0 is the mode, bit 1 is modem use and bit 3 is soft reset. All other bits read 0 whatever was written.
- R11: Writing 1 to control bit 3 makes the control register read with bit 3 = 1 for one cycle. At the next edge every register, flag and synchronizer returns to its reset value, and bit 3 reads 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (state reads clear flags) |
| addr | input | 2 | Register select: 0 direction, 1 state, 2 enable, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as `addr` |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| dtr_ctl | input | 1 | Level for the DTR pin in modem mode |
| modem_lines | output | 3 | Synchronized {RI, CD, DSR} in modem mode |
| modem_delta | output | 1 | One-cycle pulse on a modem line change |
| irq | output | 1 | OR of all pending change flags |

## Verification
The bound checker checks several rules on every cycle:
- pin ownership and DTR drive in modem mode;
- the silent modem outputs in I/O mode;
- that no latched flag clears without a state read or a configuration write;
- that a state read always leaves `irq` low;
- the two-edge sequence of the soft reset.

Only the bench scenarios can show the rest: the three-edge latency from a pin change to `irq`, the withdrawal in transparent mode versus the hold in latched mode, the captured value seen on read-back, and the single-cycle width of the modem change pulse.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DIR   = 2'd0,
        REG_STATE = 2'd1,
        REG_IEN   = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CB_LATCH = 0;
    localparam int CB_MODEM = 1;
    localparam int CB_SRST  = 3;

    // modem line offsets inside the reassigned nibble
    localparam int MOFF_DSR = 0;
    localparam int MOFF_DTR = 1;
    localparam int MOFF_CD  = 2;
    localparam int MOFF_RI  = 3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = clr ? '0 : d_in;
        d.s2 = clr ? '0 : q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign d_out = q.s2;
endmodule

// File: rtl/gpio_irq_track.sv
module gpio_irq_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         latch_mode,
    input  logic         rd_clear,
    input  logic [W-1:0] elig,
    input  logic [W-1:0] smp,
    output logic [W-1:0] pend,
    output logic [W-1:0] cap
);
    typedef struct packed {
        logic [W-1:0] refl;
        logic [W-1:0] pend;
        logic [W-1:0] cap;
    } trk_t;

    trk_t q, d;
    logic [W-1:0] fresh;

    always_comb begin
        d     = q;
        fresh = elig & ~q.pend & (smp ^ q.refl);
        if (clr) begin
            d = '0;
        end else if (rd_clear) begin
            d.refl = smp;
            d.pend = '0;
        end else if (latch_mode) begin
            // first differing level is captured and held until a read
            d.pend = (q.pend | fresh) & elig;
            d.cap  = (q.cap & ~fresh) | (smp & fresh);
            d.refl = (q.refl & elig) | (smp & ~elig);
        end else begin
            // flag follows the difference from the reference level
            d.pend = elig & (smp ^ q.refl);
            d.refl = (q.refl & elig) | (smp & ~elig);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign cap  = q.cap;
endmodule

// File: rtl/gpio_modem_port.sv
module gpio_modem_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int MODEM_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    input  logic             dtr_ctl,
    output logic [2:0]       modem_lines,
    output logic             modem_delta,
    output logic             irq
);
    localparam logic [NPINS-1:0] MODEM_MASK = {{(NPINS-4){1'b0}}, 4'hF} << MODEM_BASE;
    localparam logic [NPINS-1:0] DTR_BIT    = {{(NPINS-1){1'b0}}, 1'b1} << (MODEM_BASE + MOFF_DTR);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] outv;
        logic [NPINS-1:0] ien;
        logic             latch;
        logic             modem;
        logic             srst;
        logic [2:0]       mprev;
    } regs_t;

    regs_t q, d;

    logic [NPINS-1:0] smp, pend, cap, owned, elig, live, st_rd;
    logic [2:0]       ml_now;
    logic             rd_clear;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(addr);
    assign rd_clear = rd_en && (sel == REG_STATE);
    assign owned    = q.modem ? MODEM_MASK : '0;
    assign elig     = ~q.dir & q.ien & ~owned;
    assign ml_now   = {smp[MODEM_BASE+MOFF_RI], smp[MODEM_BASE+MOFF_CD], smp[MODEM_BASE+MOFF_DSR]};

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q.srst),
        .d_in  (pin_in),
        .d_out (smp)
    );

    gpio_irq_track #(.W(NPINS)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (q.srst),
        .latch_mode (q.latch),
        .rd_clear   (rd_clear),
        .elig       (elig),
        .smp        (smp),
        .pend       (pend),
        .cap        (cap)
    );

    always_comb begin
        d       = q;
        d.srst  = 1'b0;
        d.mprev = ml_now;
        if (wr_en) begin
            case (sel)
                REG_DIR:   d.dir  = wdata;
                REG_STATE: d.outv = wdata;
                REG_IEN:   d.ien  = wdata;
                REG_CTRL: begin
                    d.latch = wdata[CB_LATCH];
                    d.modem = wdata[CB_MODEM];
                    d.srst  = wdata[CB_SRST];
                end
                default: ;
            endcase
        end
        if (q.srst) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read path
    assign live  = q.latch ? ((pend & cap) | (~pend & smp)) : smp;
    assign st_rd = ((q.dir & q.outv) | (~q.dir & live)) & ~owned;

    always_comb begin
        rdata = '0;
        case (sel)
            REG_DIR:   rdata = q.dir;
            REG_STATE: rdata = st_rd;
            REG_IEN:   rdata = q.ien;
            REG_CTRL: begin
                rdata[CB_LATCH] = q.latch;
                rdata[CB_MODEM] = q.modem;
                rdata[CB_SRST]  = q.srst;
            end
            default: ;
        endcase
    end

    // pin drive
    assign pin_oe      = (q.dir & ~owned) | (owned & DTR_BIT);
    assign pin_out     = (q.outv & ~owned) | (owned & DTR_BIT & {NPINS{dtr_ctl}});
    assign modem_lines = q.modem ? ml_now : 3'b000;
    assign modem_delta = q.modem && (ml_now != q.mprev);
    assign irq         = |pend;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS      = 8,
    parameter int MODEM_BASE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic             wsrst,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             dtr_ctl,
    input logic [2:0]       modem_lines,
    input logic             modem_delta,
    input logic             irq,
    input logic             modem_q,
    input logic             latch_q,
    input logic             srst_q,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] pend_q
);
    // R11: soft reset request empties the block two edges later
    a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && wsrst) |=> ##1
        (dir_q == '0 && !modem_q && !latch_q && !srst_q && !irq));

    // R8: modem-owned nibble ignores port registers
    a_r8_modem_pins: assert property (@(posedge clk) disable iff (!rst_n)
        modem_q |-> (pin_oe[MODEM_BASE+3:MODEM_BASE] == 4'b0010 &&
                     pin_out[MODEM_BASE+MOFF_DTR] == dtr_ctl));

    // R9: modem status outputs stay quiet in I/O mode
    a_r9_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_q |-> (modem_lines == 3'b000 && !modem_delta));

    // R5: latched flags only clear through a read or a configuration write
    a_r5_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !rd_en && !wr_en && !srst_q) |=>
        ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6: a state read leaves no flag pending
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_STATE) |=> !irq);
endmodule

bind gpio_modem_port gpio_port_chk #(.NPINS(NPINS), .MODEM_BASE(MODEM_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wsrst       (wdata[gpio_port_pkg::CB_SRST]),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .dtr_ctl     (dtr_ctl),
    .modem_lines (modem_lines),
    .modem_delta (modem_delta),
    .irq         (irq),
    .modem_q     (q.modem),
    .latch_q     (q.latch),
    .srst_q      (q.srst),
    .dir_q       (q.dir),
    .pend_q      (pend)
);

// File: tb/sim_gpio_modem_port.sv
`timescale 1ns/1ps
module sim_gpio_modem_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, dtr_ctl = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, pin_in = 8'h00;
    logic [7:0] rdata, pin_out, pin_oe;
    logic [2:0] modem_lines;
    logic       modem_delta, irq;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    gpio_modem_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .dtr_ctl(dtr_ctl), .modem_lines(modem_lines),
        .modem_delta(modem_delta), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        cyc(1);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] own_of(input bit md);
        return md ? 8'hF0 : 8'h00;
    endfunction

    function automatic logic [7:0] exp_state(input logic [7:0] d, input logic [7:0] o,
                                             input logic [7:0] live, input bit md);
        return ((d & o) | (~d & live)) & ~own_of(md);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 irq", irq, 0);
        rd(2'd0, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 ien", v, 8'h00);
        rd(2'd3, v); chk("R1 ctrl", v, 8'h00);

        // R10 reserved control bits
        wr(2'd3, 8'hF7);
        rd(2'd3, v); chk("R10 reserved", v, 8'h03);
        wr(2'd3, 8'h00);

        // R2 register read-back and drive
        wr(2'd0, 8'hA5); wr(2'd2, 8'h3C); wr(2'd1, 8'h96);
        rd(2'd0, v); chk("R2 dir", v, 8'hA5);
        rd(2'd2, v); chk("R2 ien", v, 8'h3C);
        #1 chk("R2 oe", pin_oe, 8'hA5);
        chk("R2 out", pin_out, 8'h96);

        // R8 modem pins, R9 dtr ignored in I/O mode
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        dtr_ctl = 1'b0; #1 chk("R9 dtr ignored", pin_out, 8'hFF);
        wr(2'd3, 8'h02);
        #1 chk("R8 oe", pin_oe, 8'h2F);
        chk("R8 out dtr0", pin_out, 8'h0F);
        dtr_ctl = 1'b1; #1 chk("R8 out dtr1", pin_out, 8'h2F);
        dtr_ctl = 1'b0;

        // R9 modem change pulse, R8 no irq from owned pins
        wr(2'd0, 8'h00); wr(2'd2, 8'hFF); pin_in = 8'h00;
        cyc(3); rd(2'd1, v);
        pin_in = 8'h80;
        cyc(2); chk("R9 delta high", modem_delta, 1);
        cyc(1); chk("R9 delta one cycle", modem_delta, 0);
        chk("R9 lines", modem_lines, 3'b100);
        chk("R8 no irq", irq, 0);
        rd(2'd1, v); chk("R8 state reads 0", v & 8'hF0, 8'h00);

        // I/O mode: same pin raises irq, modem outputs silent
        wr(2'd3, 8'h00); cyc(3); rd(2'd1, v);
        pin_in = 8'h00;
        cyc(2); chk("R9 io delta", modem_delta, 0);
        cyc(1); chk("R4 io irq", irq, 1);
        chk("R9 io lines", modem_lines, 3'b000);
        rd(2'd1, v); cyc(0); chk("R6 clear", irq, 0);

        // R7 outputs raise nothing
        wr(2'd0, 8'hFF); pin_in = 8'hFF; cyc(4);
        chk("R7 outputs quiet", irq, 0);

        // randomized configurations
        for (int it = 0; it < 60; it++) begin
            logic [7:0] d, ie, o, p0, tg, el, live;
            bit lat, md;
            d = 8'($urandom); ie = 8'($urandom); o = 8'($urandom);
            p0 = 8'($urandom); tg = 8'($urandom);
            lat = 1'($urandom); md = 1'($urandom);
            if (it % 8 == 0) tg = 8'hFF;
            el = ~d & ie & ~own_of(md);
            wr(2'd0, d); wr(2'd1, o); wr(2'd2, ie); wr(2'd3, {6'd0, md, lat});
            pin_in = p0; cyc(3);
            rd(2'd1, v); chk("R3 state read", v, exp_state(d, o, p0, md));
            chk("R6 irq after read", irq, 0);
            chk("R2 oe rand", pin_oe, md ? ((d & 8'h0F) | 8'h20) : d);
            chk("R9 lines rand", modem_lines, md ? {p0[7], p0[6], p0[4]} : 3'b000);
            pin_in = p0 ^ tg; cyc(3);
            chk("R4 R7 irq on change", irq, |(tg & el));
            pin_in = p0; cyc(3);
            if (lat) chk("R5 held after return", irq, |(tg & el));
            else     chk("R4 withdrawn on return", irq, 0);
            live = lat ? ((p0 & ~(tg & el)) | (~p0 & tg & el)) : p0;
            rd(2'd1, v); chk("R5 captured read", v, exp_state(d, o, live, md));
            chk("R6 irq cleared", irq, 0);
        end

        // R11 soft reset
        wr(2'd0, 8'hFF); wr(2'd3, 8'h0B);
        rd(2'd3, v); chk("R11 bit visible", v, 8'h0B);
        rd(2'd3, v); chk("R11 self-clear", v, 8'h00);
        rd(2'd0, v); chk("R11 dir reset", v, 8'h00);
        chk("R11 oe reset", pin_oe, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule